// File: doc/BRIEF.md
# Dual Down-Counter Timer Peripheral

This block is a memory-mapped peripheral with two independent down-counting timer channels behind one synchronous register bus. A 4 KB byte-offset window is decoded to steer each access. The first 32 bytes reach channel 0. The next 32 bytes reach channel 1 with the same internal layout. The last 32 bytes return eight fixed identification bytes. Every other offset reads as zero, and writes to those offsets are dropped.

Each channel counts on its own tick-enable input, so two channels driven from one system clock can run at different rates. A tick can pass straight through or through a divide-by-16 or divide-by-256 prescaler. A channel can free-run, run periodically from a programmed reload value, or run once and stop. Each channel keeps a sticky raw interrupt flag that software clears. The flag is masked by a per-channel enable, and the two masked flags are ORed into one interrupt pin.

The bus has no back-pressure. A write completes in the cycle its strobe is high. A read strobe is always accepted, and its data is returned one cycle later together with a one-cycle valid flag.

Top module: `dual_timer_wrap`

## Requirements
- R1: Byte offsets 0x000–0x01F reach channel 0 and 0x020–0x03F reach channel 1. Inside a channel window the register is chosen by offset bits [4:2]: 0 = control, 1 = load, 2 = background load, 3 = count (read-only), 4 = raw flag, 5 = masked flag, 6 = flag clear (write-only, reads zero), 7 = reads zero.
- R2: Control bits: [0] run, [1] periodic, [2] one-shot, [3] wide (32-bit), [5:4] prescale, [6] interrupt enable. Control resets to 0x40; load, count and raw flag reset to 0; the combined interrupt resets low.
- R3: On each prescaled tick while running, a non-zero count decrements by one. A zero count expires instead: the raw flag sets and the count reloads the effective limit. The effective limit is the load value when periodic or one-shot is set; otherwise it is 0xFFFF (narrow) or 0xFFFFFFFF (wide).
- R4: In one-shot mode an expiry clears the run bit and leaves the count at zero; further ticks change nothing.
- R5: Prescale code 0 and code 3 pass every tick, code 1 passes every 16th tick and code 2 passes every 256th tick. Any control write restarts the prescale phase.
- R6: A load write reloads the count with the effective limit at once. A background-load write changes only the stored value. A control write that sets the run bit reloads the count with the new effective limit. Both load offsets read back the stored value.
- R7: In narrow mode the load value is truncated to its low 16 bits when copied into the count.
- R8: The raw flag is set by expiry and cleared by a write to the clear offset; expiry wins when both occur in one cycle. The masked flag is raw AND interrupt enable.
- R9: The interrupt output is high whenever either channel's masked flag is high.
- R10: Offsets 0xFE0–0xFFC read identification bytes, indexed by offset bits [4:2]: 0x04, 0x18, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1, in the low byte with the upper bits zero. Writes there have no effect.
- R11: Reads from all other offsets, including 0xF00 and 0xF04, return zero. Writes outside the two channel windows, and writes to the count, raw-flag and masked-flag offsets, change no state.
- R12: Read data and the read-valid flag appear in the cycle after the read strobe. Read data holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 12 | Byte offset of the access |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 32 | Registered read data |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| tick_en | input | 2 | Per-channel count enable, bit i drives channel i |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds the block with its default parameters: a 32-bit counter, a 16-bit narrow mode and prescale shifts of 4 and 8. The shift of 8 keeps the divide-by-256 boundary within a few hundred ticks, so the bench can step through the full prescale phase on either side of the passing tick. The 16-bit narrow width makes the free-running limit and load truncation exact values that can be compared directly against 32-bit wide mode.

// File: rtl/dt_pkg.sv
package dt_pkg;

  typedef enum logic [1:0] {
    PS_DIV1   = 2'd0,
    PS_DIV16  = 2'd1,
    PS_DIV256 = 2'd2,
    PS_RSVD   = 2'd3
  } prescale_e;

  typedef struct packed {
    logic      ie;
    prescale_e ps;
    logic      wide;
    logic      oneshot;
    logic      periodic;
    logic      en;
  } ctrl_t;

  localparam int CTRL_W = 7;
  localparam ctrl_t CTRL_RESET = '{ie: 1'b1, ps: PS_DIV1, wide: 1'b0,
                                   oneshot: 1'b0, periodic: 1'b0, en: 1'b0};

  localparam logic [2:0] REG_CTRL   = 3'd0;
  localparam logic [2:0] REG_LOAD   = 3'd1;
  localparam logic [2:0] REG_BGLOAD = 3'd2;
  localparam logic [2:0] REG_COUNT  = 3'd3;
  localparam logic [2:0] REG_RAW    = 3'd4;
  localparam logic [2:0] REG_MASK   = 3'd5;
  localparam logic [2:0] REG_CLR    = 3'd6;

  function automatic logic [7:0] ident_byte(input logic [2:0] idx);
    case (idx)
      3'd0:    ident_byte = 8'h04;
      3'd1:    ident_byte = 8'h18;
      3'd2:    ident_byte = 8'h14;
      3'd3:    ident_byte = 8'h00;
      3'd4:    ident_byte = 8'h0D;
      3'd5:    ident_byte = 8'hF0;
      3'd6:    ident_byte = 8'h05;
      default: ident_byte = 8'hB1;
    endcase
  endfunction

endpackage

// File: rtl/dt_prescale.sv
module dt_prescale
  import dt_pkg::*;
#(
  parameter int SHIFT_A = 4,
  parameter int SHIFT_B = 8
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      restart,
  input  prescale_e sel,
  output logic      pulse
);

  localparam int PW = SHIFT_B;

  logic [PW-1:0] phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (restart) begin
      phase_q <= '0;
    end else if (tick) begin
      phase_q <= phase_q + 1'b1;
    end
  end

  always_comb begin
    unique case (sel)
      PS_DIV16:  pulse = tick && (phase_q[SHIFT_A-1:0] == '1);
      PS_DIV256: pulse = tick && (phase_q == '1);
      default:   pulse = tick;
    endcase
  end

  // R5: a divided pulse never arrives right after a restart
  p_restart_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && sel != PS_DIV1 && sel != PS_RSVD) |=> !pulse);

endmodule

// File: rtl/dt_channel.sv
module dt_channel
  import dt_pkg::*;
#(
  parameter int DW      = 32,
  parameter int NW      = 16,
  parameter int SHIFT_A = 4,
  parameter int SHIFT_B = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          wr_en,
  input  logic [2:0]    idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rd_data,
  output logic          irq
);

  localparam logic [DW-1:0] NARROW_MASK = {{(DW-NW){1'b0}}, {NW{1'b1}}};

  ctrl_t         ctrl_q;
  ctrl_t         ctrl_new;
  logic [DW-1:0] load_q;
  logic [DW-1:0] cnt_q;
  logic          raw_q;
  logic          pulse;
  logic          expire;
  logic          wr_ctrl, wr_load, wr_bg, wr_clr;

  function automatic logic [DW-1:0] eff_limit(input ctrl_t c, input logic [DW-1:0] ld);
    if (!c.periodic && !c.oneshot)
      eff_limit = c.wide ? '1 : NARROW_MASK;
    else
      eff_limit = c.wide ? ld : (ld & NARROW_MASK);
  endfunction

  assign ctrl_new = ctrl_t'(wdata[CTRL_W-1:0]);
  assign wr_ctrl  = wr_en && (idx == REG_CTRL);
  assign wr_load  = wr_en && (idx == REG_LOAD);
  assign wr_bg    = wr_en && (idx == REG_BGLOAD);
  assign wr_clr   = wr_en && (idx == REG_CLR);

  dt_prescale #(.SHIFT_A(SHIFT_A), .SHIFT_B(SHIFT_B)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick_en && ctrl_q.en),
    .restart (wr_ctrl),
    .sel     (ctrl_q.ps),
    .pulse   (pulse)
  );

  assign expire = pulse && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RESET;
    end else if (wr_ctrl) begin
      ctrl_q <= ctrl_new;
    end else if (expire && ctrl_q.oneshot) begin
      ctrl_q.en <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= '0;
    end else if (wr_load || wr_bg) begin
      load_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (wr_load) begin
      cnt_q <= eff_limit(ctrl_q, wdata);
    end else if (wr_ctrl) begin
      if (ctrl_new.en) cnt_q <= eff_limit(ctrl_new, load_q);
    end else if (pulse) begin
      if (cnt_q != '0)          cnt_q <= cnt_q - 1'b1;
      else if (!ctrl_q.oneshot) cnt_q <= eff_limit(ctrl_q, load_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= 1'b0;
    end else if (expire) begin
      raw_q <= 1'b1;
    end else if (wr_clr) begin
      raw_q <= 1'b0;
    end
  end

  always_comb begin
    rd_data = '0;
    unique case (idx)
      REG_CTRL:   rd_data = DW'(ctrl_q);
      REG_LOAD:   rd_data = load_q;
      REG_BGLOAD: rd_data = load_q;
      REG_COUNT:  rd_data = cnt_q;
      REG_RAW:    rd_data = DW'(raw_q);
      REG_MASK:   rd_data = DW'(raw_q && ctrl_q.ie);
      default:    rd_data = '0;
    endcase
  end

  assign irq = raw_q && ctrl_q.ie;

  // R3: a prescaled tick on a non-zero count decrements it
  p_decrement_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse && cnt_q != '0 && !wr_load && !wr_ctrl) |=> cnt_q == $past(cnt_q) - 1'b1);

  // R4: one-shot expiry stops the channel at zero
  p_oneshot_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && ctrl_q.oneshot && !wr_ctrl && !wr_load) |=> (!ctrl_q.en && cnt_q == '0));

  // R7: narrow load keeps the count within 16 bits
  p_narrow_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_load && !ctrl_q.wide) |=> cnt_q[DW-1:NW] == '0);

  // R8: the raw flag only rises after an expiry
  p_raw_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(raw_q) |-> $past(expire));

endmodule

// File: rtl/dual_timer_wrap.sv
module dual_timer_wrap
  import dt_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DW        = 32,
  parameter int NW        = 16,
  parameter int WIN_SHIFT = 5,
  parameter int SHIFT_A   = 4,
  parameter int SHIFT_B   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [DW-1:0]     rdata,
  output logic              rd_valid,
  input  logic [1:0]        tick_en,
  output logic              irq
);

  localparam int NUM_CH = 2;
  localparam int WIN_W  = ADDR_W - WIN_SHIFT;
  localparam logic [WIN_W-1:0] ID_WIN = '1;

  logic [WIN_W-1:0] win;
  logic [2:0]       ridx;
  logic [DW-1:0]    ch_rd [NUM_CH];
  logic [NUM_CH-1:0] ch_irq;
  logic [NUM_CH-1:0] ch_sel;
  logic             in_id;
  logic [DW-1:0]    rd_next;
  logic [DW-1:0]    rdata_q;
  logic             rvalid_q;
  logic             unused_lsb;

  assign win        = addr[ADDR_W-1:WIN_SHIFT];
  assign ridx       = addr[WIN_SHIFT-1:2];
  assign in_id      = (win == ID_WIN);
  assign unused_lsb = ^addr[1:0];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign ch_sel[g] = (win == WIN_W'(g));
    dt_channel #(.DW(DW), .NW(NW), .SHIFT_A(SHIFT_A), .SHIFT_B(SHIFT_B)) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_en (tick_en[g]),
      .wr_en   (wr_en && ch_sel[g]),
      .idx     (ridx),
      .wdata   (wdata),
      .rd_data (ch_rd[g]),
      .irq     (ch_irq[g])
    );
  end

  always_comb begin
    rd_next = '0;
    for (int k = 0; k < NUM_CH; k++) begin
      if (ch_sel[k]) rd_next = ch_rd[k];
    end
    if (in_id) rd_next = DW'(ident_byte(ridx));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_en;
      if (rd_en) rdata_q <= rd_next;
    end
  end

  assign rdata    = rdata_q;
  assign rd_valid = rvalid_q;
  assign irq      = |ch_irq;

  // R12: every read strobe is answered in the next cycle
  p_read_latency_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  // R12: read data holds between reads
  p_read_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

  // R10: identification reads carry only a byte
  p_ident_byte_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && in_id) |=> rdata[DW-1:8] == '0);

  // R11: reads outside every window return zero
  p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !in_id && ch_sel == '0) |=> rdata == '0);

endmodule

// File: tb/sim_dual_timer_wrap.sv
`timescale 1ns/1ps
module sim_dual_timer_wrap;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [31:0] rdata;
  logic        rd_valid;
  logic [1:0]  tick_en = 2'b00;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  dual_timer_wrap u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rd_en(rd_en), .rdata(rdata), .rd_valid(rd_valid), .tick_en(tick_en), .irq(irq)
  );

  function automatic logic [7:0] exp_ident(input int i);
    logic [7:0] t [8] = '{8'h04, 8'h18, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    return t[i];
  endfunction

  // control: [0] run [1] periodic [2] one-shot [3] wide [6] ie
  function automatic logic [31:0] exp_limit(input logic [31:0] c, input logic [31:0] ld);
    if (!c[1] && !c[2]) return c[3] ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    return c[3] ? ld : (ld & 32'h0000_FFFF);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    chk("R12 valid", {31'b0, rd_valid}, 32'd1);
    d = rdata;
  endtask

  task automatic rdchk(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic tick(input int ch, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick_en[ch] = 1'b1;
      @(negedge clk);
      tick_en[ch] = 1'b0;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      finish_run();
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'h5EED_0A11));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state (R2)
    chk("R2 irq reset", {31'b0, irq}, 32'd0);
    rdchk("R2 ctrl reset", 12'h000, 32'h40);
    rdchk("R2 load reset", 12'h004, 32'h0);
    rdchk("R2 count reset", 12'h00C, 32'h0);
    rdchk("R2 raw reset", 12'h010, 32'h0);
    rdchk("R2 ch1 ctrl reset", 12'h020, 32'h40);

    // identification and unmapped (R10, R11)
    for (int i = 0; i < 8; i++) rdchk("R10 ident", 12'hFE0 + 12'(i*4), {24'b0, exp_ident(i)});
    rdchk("R11 test ctrl", 12'hF00, 32'h0);
    rdchk("R11 test out", 12'hF04, 32'h0);
    rdchk("R11 gap", 12'h040, 32'h0);
    rdchk("R1 ch clr reads zero", 12'h018, 32'h0);

    // load / background load / control reload (R6, R1)
    wr(12'h004, 32'd3);
    rdchk("R6 load reloads count", 12'h00C, 32'h0000_FFFF); // free narrow limit
    wr(12'h000, 32'h42);
    wr(12'h004, 32'd3);
    rdchk("R6 load reload periodic", 12'h00C, 32'd3);
    wr(12'h008, 32'd10);
    rdchk("R6 bg keeps count", 12'h00C, 32'd3);
    rdchk("R6 bg readback", 12'h004, 32'd10);
    rdchk("R6 bg readback alt", 12'h008, 32'd10);
    wr(12'h000, 32'h43);
    rdchk("R6 run reloads", 12'h00C, 32'd10);

    // counting and expiry (R3, R8, R9)
    tick(0, 4);
    rdchk("R3 decrement", 12'h00C, 32'd6);
    tick(0, 6);
    rdchk("R3 reach zero", 12'h00C, 32'd0);
    chk("R9 no irq yet", {31'b0, irq}, 32'd0);
    tick(0, 1);
    chk("R9 irq on expiry", {31'b0, irq}, 32'd1);
    rdchk("R3 periodic reload", 12'h00C, 32'd10);
    rdchk("R8 raw set", 12'h010, 32'd1);
    wr(12'h018, 32'd0);
    rdchk("R8 raw cleared", 12'h010, 32'd0);
    chk("R9 irq cleared", {31'b0, irq}, 32'd0);

    // masked flag (R8)
    wr(12'h000, 32'h03);
    tick(0, 11);
    rdchk("R8 raw when masked", 12'h010, 32'd1);
    rdchk("R8 masked zero", 12'h014, 32'd0);
    chk("R9 masked no irq", {31'b0, irq}, 32'd0);
    wr(12'h018, 32'd0);

    // one-shot (R4)
    wr(12'h004, 32'd2);
    wr(12'h000, 32'h45);
    tick(0, 3);
    rdchk("R4 run cleared", 12'h000, 32'h44);
    rdchk("R4 count zero", 12'h00C, 32'd0);
    rdchk("R4 masked set", 12'h014, 32'd1);
    wr(12'h018, 32'd0);
    tick(0, 2);
    rdchk("R4 stays zero", 12'h00C, 32'd0);
    rdchk("R4 no new expiry", 12'h010, 32'd0);

    // prescale (R5)
    wr(12'h004, 32'd4);
    wr(12'h000, 32'h53);
    tick(0, 15);
    rdchk("R5 div16 before", 12'h00C, 32'd4);
    tick(0, 1);
    rdchk("R5 div16 pulse", 12'h00C, 32'd3);
    wr(12'h000, 32'h63);
    tick(0, 255);
    rdchk("R5 div256 before", 12'h00C, 32'd4);
    tick(0, 1);
    rdchk("R5 div256 pulse", 12'h00C, 32'd3);
    wr(12'h000, 32'h73);
    tick(0, 1);
    rdchk("R5 code3 passes", 12'h00C, 32'd3);

    // free running and width (R3, R7)
    wr(12'h000, 32'h41);
    rdchk("R3 free narrow limit", 12'h00C, 32'h0000_FFFF);
    wr(12'h000, 32'h49);
    rdchk("R3 free wide limit", 12'h00C, 32'hFFFF_FFFF);
    tick(0, 1);
    rdchk("R3 wide decrement", 12'h00C, 32'hFFFF_FFFE);
    wr(12'h000, 32'h42);
    rdchk("R6 stop keeps count", 12'h00C, 32'hFFFF_FFFE);
    wr(12'h004, 32'h0001_2345);
    rdchk("R7 narrow truncation", 12'h00C, 32'h0000_2345);
    rdchk("R7 load stored full", 12'h004, 32'h0001_2345);
    wr(12'h000, 32'h40);

    // channel 1 independence (R1, R9)
    wr(12'h024, 32'd7);
    wr(12'h020, 32'h43);
    rdchk("R1 ch1 count", 12'h02C, 32'd7);
    tick(1, 7);
    rdchk("R1 ch1 zero", 12'h02C, 32'd0);
    rdchk("R1 ch0 untouched", 12'h00C, 32'h0000_2345);
    tick(1, 1);
    chk("R9 irq from ch1", {31'b0, irq}, 32'd1);
    rdchk("R1 ch0 raw clear", 12'h010, 32'd0);
    rdchk("R1 ch1 raw", 12'h030, 32'd1);
    wr(12'h038, 32'd0);
    chk("R9 irq ch1 cleared", {31'b0, irq}, 32'd0);

    // expiry beats clear (R8)
    tick(1, 7);
    @(negedge clk);
    tick_en[1] = 1'b1; addr = 12'h038; wdata = '0; wr_en = 1'b1;
    @(negedge clk);
    tick_en[1] = 1'b0; wr_en = 1'b0;
    chk("R8 expiry wins", {31'b0, irq}, 32'd1);
    wr(12'h038, 32'd0);

    // ignored writes (R11, R10)
    wr(12'h000, 32'h40);
    wr(12'h020, 32'h40);
    wr(12'h00C, 32'h55);
    rdchk("R11 count read-only", 12'h00C, 32'h0000_2345);
    wr(12'h010, 32'd1);
    rdchk("R11 raw read-only", 12'h010, 32'd0);
    chk("R11 irq unchanged", {31'b0, irq}, 32'd0);
    wr(12'hFE0, 32'hFF);
    rdchk("R10 ident write ignored", 12'hFE0, 32'h04);
    wr(12'h040, 32'h99);
    wr(12'hF00, 32'h99);
    rdchk("R11 ch0 load kept", 12'h004, 32'h0001_2345);
    rdchk("R11 ch1 load kept", 12'h024, 32'd7);
    rdchk("R11 ch0 ctrl kept", 12'h000, 32'h40);

    // random register traffic (R6, R1, R11)
    wr(12'h000, 32'h4A);
    wr(12'h020, 32'h4A);
    for (int i = 0; i < 60; i++) begin
      int ch;
      logic [11:0] base;
      logic [31:0] val;
      logic [11:0] ua;
      ch   = $urandom % 2;
      base = (ch == 0) ? 12'h000 : 12'h020;
      val  = $urandom;
      if ($urandom % 2 == 0) begin
        wr(base + 12'h004, val);
        rdchk("R6 rand count", base + 12'h00C, exp_limit(32'h4A, val));
      end else begin
        rd(base + 12'h00C, v);
        wr(base + 12'h008, val);
        rdchk("R6 rand bg count", base + 12'h00C, v);
      end
      rdchk("R6 rand readback", base + 12'h008, val);
      ua = 12'h040 + 12'(($urandom % 944) * 4);
      rdchk("R11 rand unmapped", ua, 32'h0);
    end

    finish_run();
  end

endmodule